// File: doc/BRIEF.md
# Exception Restart PC Tracker

This block holds the program counter of a processor core together with a flag that says whether the core is executing the compressed (16-bit) instruction encoding. It works out, every cycle, the address at which execution resumes after an exception. The instruction-set mode sits in bit 0 of that address. When the faulting instruction is in a branch delay slot, the address points back at the branch, by an amount set by the branch's encoding width.

Control logic writes the PC, marks delay-slot state, and pulses a strobe when it takes an exception; the block then latches the resume address into an exception-return register. A soft core reset latches a separate error-return address. It then forces the PC to the exception base and picks the reset instruction-set mode. The exception base can be replaced through a configuration port, but only while the core reset is held.

Top module: `rpc_tracker`

## Requirements
- R1: A PC load (`pc_ld` high) stores `pc_ld_val` with bit 0 forced to 0 on the next edge, and sets `mode_o` to bit 0 of the loaded value (1 = compressed mode, 0 = standard mode).
- R2: When not in a delay slot, `restart_pc_o` equals `pc_o` with `mode_o` placed in bit 0.
- R3: `slot_wr` loads the delay-slot state from `slot_in` and `slot_b16`. While in a slot, `restart_pc_o` is the R2 value minus 2 if the branch was 16-bit (`slot_b16` = 1) and minus 4 if it was 32-bit, with wrap-around modulo 2^XLEN.
- R4: On `exc_take`, `epc_o` takes the value `restart_pc_o` had in that cycle and the delay-slot state is cleared. A `pc_ld` or `slot_wr` in the same cycle has no effect.
- R5: In the first cycle of `core_reset`, `errorpc_o` captures `pc_o` minus the delay-slot rewind (2 or 4, or 0 when not in a slot), without the mode bit. Later cycles of a held reset leave `errorpc_o` unchanged.
- R6: Each cycle `core_reset` is high, the PC is loaded with the exception base, the delay-slot state is cleared, and `mode_o` becomes 1 exactly when `reset_isa` equals 2'b11. `core_reset` takes priority over `exc_take`, `pc_ld` and `slot_wr`.
- R7: After `rst_n` the exception base is 0xBFC00000 sign-extended to XLEN, `pc_o` equals that base, `mode_o`, `epc_o` and `errorpc_o` are 0, and the core is not in a delay slot.
- R8: A `base_we` write takes effect only while `core_reset` is high; the written value is loaded into the PC in that same cycle and kept as the base for later resets. A `base_we` write with `core_reset` low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| core_reset | input | 1 | Soft core reset, level sensitive |
| reset_isa | input | 2 | Reset instruction-set selection; 2'b11 selects compressed mode |
| base_we | input | 1 | Exception base write enable (honoured only under core_reset) |
| base_val | input | XLEN | New exception base value |
| pc_ld | input | 1 | PC load strobe |
| pc_ld_val | input | XLEN | PC load value, bit 0 is the mode |
| slot_wr | input | 1 | Delay-slot state write strobe |
| slot_in | input | 1 | New delay-slot flag |
| slot_b16 | input | 1 | Branch owning the slot is a 16-bit encoding |
| exc_take | input | 1 | Exception taken strobe |
| pc_o | output | XLEN | Current PC, bit 0 always 0 |
| mode_o | output | 1 | Compressed-mode flag |
| restart_pc_o | output | XLEN | Computed resume address |
| epc_o | output | XLEN | Latched exception-return PC |
| errorpc_o | output | XLEN | Latched error-return PC |

## Verification
The assertions check these on every cycle: the load rule, the exception-return latch, and the clearing of the slot after an exception. They also check that the error-return capture equals the resume address with bit 0 dropped, that a held reset leaves it alone, and that the PC and mode are forced under reset. They also confirm that the base never moves outside reset. The exact rewind amounts for each branch width, the wrap at address zero, and the exception base after an override or an ignored write come from computed expectations in the bench's scenarios. The same holds for how the priorities resolve when strobes collide.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

  typedef enum logic {
    BR_WIDE   = 1'b0,
    BR_NARROW = 1'b1
  } br_width_e;

  localparam logic [1:0] ISA_SEL_COMPRESSED = 2'b11;

  // Bytes to wind back to the branch owning a delay slot.
  function automatic logic [2:0] rewind_bytes(input logic in_slot, input br_width_e w);
    logic [2:0] amt;
    if (!in_slot)              amt = 3'd0;
    else if (w == BR_NARROW)   amt = 3'd2;
    else                       amt = 3'd4;
    return amt;
  endfunction

  function automatic logic reset_mode(input logic [1:0] isa_sel);
    return isa_sel == ISA_SEL_COMPRESSED;
  endfunction

endpackage

// File: rtl/rpt_pc_mode.sv
module rpt_pc_mode #(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] INIT_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            force_en,
  input  logic [XLEN-1:0] force_pc,
  input  logic            force_mode,
  input  logic            load_en,
  input  logic [XLEN-1:0] load_val,
  output logic [XLEN-1:0] pc_q,
  output logic            mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= INIT_PC;
      mode_q <= 1'b0;
    end else if (force_en) begin
      pc_q   <= {force_pc[XLEN-1:1], 1'b0};
      mode_q <= force_mode;
    end else if (load_en) begin
      pc_q   <= {load_val[XLEN-1:1], 1'b0};
      mode_q <= load_val[0];
    end
  end

endmodule

// File: rtl/rpt_slot.sv
module rpt_slot
  import rpt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      wr,
  input  logic      flag_in,
  input  logic      narrow_in,
  output logic      active_q,
  output br_width_e width_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      width_q  <= BR_WIDE;
    end else if (clr) begin
      active_q <= 1'b0;
    end else if (wr) begin
      active_q <= flag_in;
      width_q  <= narrow_in ? BR_NARROW : BR_WIDE;
    end
  end

endmodule

// File: rtl/rpt_base.sv
module rpt_base #(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] INIT_BASE = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_reset,
  input  logic            wr,
  input  logic [XLEN-1:0] wr_val,
  output logic [XLEN-1:0] base_q,
  output logic [XLEN-1:0] base_eff
);

  logic accept;
  assign accept   = in_reset & wr;
  assign base_eff = accept ? wr_val : base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      base_q <= INIT_BASE;
    else if (accept) base_q <= wr_val;
  end

endmodule

// File: rtl/rpt_ret.sv
module rpt_ret #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            epc_cap,
  input  logic [XLEN-1:0] epc_val,
  input  logic            err_cap,
  input  logic [XLEN-1:0] err_val,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] err_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q <= '0;
      err_q <= '0;
    end else begin
      if (epc_cap) epc_q <= epc_val;
      if (err_cap) err_q <= err_val;
    end
  end

endmodule

// File: rtl/rpc_tracker.sv
module rpc_tracker
  import rpt_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [31:0] BASE_LO32 = 32'hBFC0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_reset,
  input  logic [1:0]      reset_isa,
  input  logic            base_we,
  input  logic [XLEN-1:0] base_val,
  input  logic            pc_ld,
  input  logic [XLEN-1:0] pc_ld_val,
  input  logic            slot_wr,
  input  logic            slot_in,
  input  logic            slot_b16,
  input  logic            exc_take,
  output logic [XLEN-1:0] pc_o,
  output logic            mode_o,
  output logic [XLEN-1:0] restart_pc_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] errorpc_o
);

  localparam logic signed [31:0] BASE_S32 = BASE_LO32;
  localparam logic [XLEN-1:0]    DEF_BASE = XLEN'(BASE_S32);

  // Named internal events
  logic            core_reset_q;
  logic            reset_start;
  logic            exc_event;
  logic            load_event;
  logic            slot_event;
  logic            slot_active;
  br_width_e       slot_width;
  logic [2:0]      rewind;
  logic [XLEN-1:0] base_q;
  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] err_calc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_reset_q <= 1'b0;
    else        core_reset_q <= core_reset;
  end

  assign reset_start = core_reset & ~core_reset_q;
  assign exc_event   = exc_take & ~core_reset;
  assign load_event  = pc_ld & ~core_reset & ~exc_take;
  assign slot_event  = slot_wr & ~core_reset & ~exc_take;

  rpt_base #(.XLEN(XLEN), .INIT_BASE(DEF_BASE)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_reset (core_reset),
    .wr       (base_we),
    .wr_val   (base_val),
    .base_q   (base_q),
    .base_eff (base_eff)
  );

  rpt_pc_mode #(.XLEN(XLEN), .INIT_PC(DEF_BASE)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_en   (core_reset),
    .force_pc   (base_eff),
    .force_mode (reset_mode(reset_isa)),
    .load_en    (load_event),
    .load_val   (pc_ld_val),
    .pc_q       (pc_o),
    .mode_q     (mode_o)
  );

  rpt_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (core_reset | exc_take),
    .wr        (slot_event),
    .flag_in   (slot_in),
    .narrow_in (slot_b16),
    .active_q  (slot_active),
    .width_q   (slot_width)
  );

  assign rewind       = rewind_bytes(slot_active, slot_width);
  assign restart_pc_o = {pc_o[XLEN-1:1], mode_o} - XLEN'(rewind);
  assign err_calc     = pc_o - XLEN'(rewind);

  rpt_ret #(.XLEN(XLEN)) u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .epc_cap (exc_event),
    .epc_val (restart_pc_o),
    .err_cap (reset_start),
    .err_val (err_calc),
    .epc_q   (epc_o),
    .err_q   (errorpc_o)
  );

endmodule

// File: rtl/rpc_tracker_chk.sv
module rpc_tracker_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_reset,
  input logic            core_reset_q,
  input logic [1:0]      reset_isa,
  input logic            base_we,
  input logic [XLEN-1:0] base_q,
  input logic            pc_ld,
  input logic [XLEN-1:0] pc_ld_val,
  input logic            exc_take,
  input logic            slot_active,
  input logic [XLEN-1:0] pc_o,
  input logic            mode_o,
  input logic [XLEN-1:0] restart_pc_o,
  input logic [XLEN-1:0] epc_o,
  input logic [XLEN-1:0] errorpc_o
);

  // R1
  load_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld && !exc_take && !core_reset) |=>
      (pc_o == {$past(pc_ld_val[XLEN-1:1]), 1'b0}) && (mode_o == $past(pc_ld_val[0])));

  // R4
  epc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !core_reset) |=> epc_o == $past(restart_pc_o));

  // R4
  slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !slot_active);

  // R5
  errpc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_reset && !core_reset_q) |=>
      errorpc_o == {$past(restart_pc_o[XLEN-1:1]), 1'b0});

  // R5
  errpc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_reset && core_reset_q) |=> $stable(errorpc_o));

  // R6
  reset_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_reset && !base_we) |=>
      (pc_o == $past(base_q)) && (mode_o == ($past(reset_isa) == 2'b11)) && !slot_active);

  // R8
  base_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_reset |=> $stable(base_q));

endmodule

bind rpc_tracker rpc_tracker_chk #(.XLEN(XLEN)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_reset   (core_reset),
  .core_reset_q (core_reset_q),
  .reset_isa    (reset_isa),
  .base_we      (base_we),
  .base_q       (base_q),
  .pc_ld        (pc_ld),
  .pc_ld_val    (pc_ld_val),
  .exc_take     (exc_take),
  .slot_active  (slot_active),
  .pc_o         (pc_o),
  .mode_o       (mode_o),
  .restart_pc_o (restart_pc_o),
  .epc_o        (epc_o),
  .errorpc_o    (errorpc_o)
);

// File: tb/test_rpc_tracker.sv
module test_rpc_tracker;

  localparam int W = 32;
  localparam int NV = 7;
  // {load value, in slot, 16-bit branch}
  localparam logic [33:0] VEC [NV] = '{
    {32'h0000_1000, 1'b0, 1'b0},
    {32'h0000_2001, 1'b0, 1'b0},
    {32'h0040_0100, 1'b1, 1'b0},
    {32'h0040_0101, 1'b1, 1'b1},
    {32'h8000_0003, 1'b1, 1'b0},
    {32'h0000_0003, 1'b1, 1'b1},
    {32'h0000_0000, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_reset = 1'b0;
  logic [1:0] reset_isa = 2'b00;
  logic base_we = 1'b0;
  logic [W-1:0] base_val = '0;
  logic pc_ld = 1'b0;
  logic [W-1:0] pc_ld_val = '0;
  logic slot_wr = 1'b0;
  logic slot_in = 1'b0;
  logic slot_b16 = 1'b0;
  logic exc_take = 1'b0;
  logic [W-1:0] pc_o, restart_pc_o, epc_o, errorpc_o;
  logic mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rpc_tracker #(.XLEN(W)) i_rpc_tracker (
    .clk(clk), .rst_n(rst_n), .core_reset(core_reset), .reset_isa(reset_isa),
    .base_we(base_we), .base_val(base_val), .pc_ld(pc_ld), .pc_ld_val(pc_ld_val),
    .slot_wr(slot_wr), .slot_in(slot_in), .slot_b16(slot_b16), .exc_take(exc_take),
    .pc_o(pc_o), .mode_o(mode_o), .restart_pc_o(restart_pc_o), .epc_o(epc_o),
    .errorpc_o(errorpc_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    pc_ld = 0; slot_wr = 0; exc_take = 0; base_we = 0; core_reset = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R7 reset state
    chk("R7 pc", pc_o, 32'hBFC0_0000);
    chk("R7 mode", {31'd0, mode_o}, 32'd0);
    chk("R7 epc", epc_o, 32'd0);
    chk("R7 errorpc", errorpc_o, 32'd0);
    chk("R7 restart", restart_pc_o, 32'hBFC0_0000);

    // Vector walk: R1, R2, R3, R4
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      logic [31:0] adj;
      logic [31:0] exp_r;
      v = VEC[i][33:2];
      adj = VEC[i][1] ? (VEC[i][0] ? 32'd2 : 32'd4) : 32'd0;
      exp_r = v - adj;
      pc_ld = 1; pc_ld_val = v;
      slot_wr = 1; slot_in = VEC[i][1]; slot_b16 = VEC[i][0];
      step();
      idle();
      chk("R1 pc", pc_o, v & ~32'd1);
      chk("R1 mode", {31'd0, mode_o}, {31'd0, v[0]});
      chk(VEC[i][1] ? "R3 restart" : "R2 restart", restart_pc_o, exp_r);
      exc_take = 1;
      step();
      idle();
      chk("R4 epc", epc_o, exp_r);
      chk("R4 slot cleared", restart_pc_o, v);
    end

    // R4: exception blocks a same-cycle load and slot write
    pc_ld = 1; pc_ld_val = 32'h0000_0100;
    step(); idle();
    exc_take = 1; pc_ld = 1; pc_ld_val = 32'h0000_0501; slot_wr = 1; slot_in = 1; slot_b16 = 0;
    step(); idle();
    chk("R4 load ignored", pc_o, 32'h0000_0100);
    chk("R4 epc", epc_o, 32'h0000_0100);
    chk("R4 slot write ignored", restart_pc_o, 32'h0000_0100);

    // R5/R6: one-cycle core reset from a 16-bit slot
    pc_ld = 1; pc_ld_val = 32'h0000_3001; slot_wr = 1; slot_in = 1; slot_b16 = 1;
    step(); idle();
    chk("R3 narrow", restart_pc_o, 32'h0000_2FFF);
    core_reset = 1; reset_isa = 2'b00; exc_take = 1;
    step(); idle();
    chk("R5 errorpc", errorpc_o, 32'h0000_2FFE);
    chk("R6 pc", pc_o, 32'hBFC0_0000);
    chk("R6 mode", {31'd0, mode_o}, 32'd0);
    chk("R6 restart", restart_pc_o, 32'hBFC0_0000);
    chk("R6 exc blocked", epc_o, 32'h0000_0100);

    // R5/R6: held reset with compressed reset ISA
    pc_ld = 1; pc_ld_val = 32'h0000_0700; slot_wr = 1; slot_in = 1; slot_b16 = 0;
    step(); idle();
    core_reset = 1; reset_isa = 2'b11;
    repeat (3) step();
    chk("R5 held errorpc", errorpc_o, 32'h0000_06FC);
    chk("R6 mode compressed", {31'd0, mode_o}, 32'd1);
    chk("R6 restart", restart_pc_o, 32'hBFC0_0001);
    reset_isa = 2'b10;
    step();
    chk("R6 mode isa10", {31'd0, mode_o}, 32'd0);

    // R8: base override while in reset
    base_we = 1; base_val = 32'h1000_0000;
    step(); idle();
    chk("R8 override pc", pc_o, 32'h1000_0000);
    base_we = 1; base_val = 32'h2222_0000;
    step(); idle();
    chk("R8 write ignored pc", pc_o, 32'h1000_0000);
    reset_isa = 2'b00; core_reset = 1;
    step(); idle();
    chk("R8 base kept", pc_o, 32'h1000_0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule